// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns a 32-bit virtual data address into a physical address for a load or a store. The region of the address and the privilege level decide whether the address goes out unchanged, goes out with its top three bits cleared, or goes through a 64-entry unified translation table. A table lookup matches the page number under a per-entry page-size mask, optionally compares the address-space identifier, and then applies the access rules for reads and writes. A write to a page whose dirty flag is clear is refused with its own fault.

Each request is decided combinationally and the answer appears on the registered outputs one clock later. A faulting request returns a 3-bit code. For faults raised by the table (miss, protection, first write, multiple hit) the block also records the whole faulting address and its page number in two registers. The table contents are inputs: loading and replacing entries is done elsewhere.

Top module: `dxlat_unit`

## Requirements
- R1: In privileged mode an address with bits 31:29 all set passes through unchanged. An address from 0x80000000 to 0xBFFFFFFF passes through with bits 31:29 cleared. The store-queue lock input has no effect on privileged accesses. Privileged addresses from 0xC0000000 to 0xDFFFFFFF are translated like low addresses.
- R2: In user mode any address with bit 31 set raises an address error: code 0 for a read, code 1 for a write. The exception is 0xE0000000 to 0xE3FFFFFF, which passes through unchanged while sqLock is 0.
- R3: When xlatEnable is 0, any address that R1 and R2 do not claim maps to the address ANDed with 0x1FFFFFFF, and no fault is raised.
- R4: The ASID is compared when singleVirt is 0 or the access is from user mode. An entry with its share flag set matches any ASID. A privileged access with singleVirt set ignores the ASID.
- R5: An entry hits when it is valid and its page number equals the address under its page mask. tlbSize values 0, 1, 2 and 3 select 1 KB, 4 KB, 64 KB and 1 MB pages. The physical address is (PPN AND mask) OR (address AND NOT mask).
- R6: When no entry hits, the access is a miss: code 2 for a read, code 3 for a write. An entry whose valid flag is clear never hits.
- R7: More than one hitting entry raises code 7. This code takes priority over every protection check.
- R8: A user-mode read of an entry whose user flag is clear raises code 4. A privileged read does not.
- R9: A privileged write needs the writable flag. A user write needs both the user flag and the writable flag. A failure raises code 5.
- R10: A write that passes protection to an entry whose dirty flag is clear raises code 6.
- R11: On codes 2 to 7, faultAddr takes the full address and faultVpn takes address bits 31:10. Address errors and faultless responses leave both unchanged. Both reset to zero.
- R12: rspValid follows reqValid one clock later, and every result appears in that same cycle. physAddr is zero whenever faultFlag is set, and all outputs are zero in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| privMode | input | 1 | 1 for privileged, 0 for user |
| xlatEnable | input | 1 | Translation enable |
| singleVirt | input | 1 | Privileged accesses skip the ASID compare |
| sqLock | input | 1 | Blocks user access to the store-queue window |
| curAsid | input | 8 | Current address-space identifier |
| tlbValid | input | 64 | Per-entry valid flag |
| tlbShare | input | 64 | Per-entry shared flag |
| tlbUser | input | 64 | Per-entry user-access flag |
| tlbWrite | input | 64 | Per-entry writable flag |
| tlbDirty | input | 64 | Per-entry dirty flag |
| tlbSize | input | 64x2 | Per-entry page size |
| tlbAsid | input | 64x8 | Per-entry ASID |
| tlbVpn | input | 64x22 | Per-entry virtual page number (address bits 31:10) |
| tlbPpn | input | 64x19 | Per-entry physical page number (bits 28:10) |
| rspValid | output | 1 | Result valid |
| physAddr | output | 32 | Physical address |
| faultFlag | output | 1 | Request faulted |
| faultCode | output | 3 | Fault code |
| faultAddr | output | 32 | Last logged faulting address |
| faultVpn | output | 22 | Page number of the last logged fault |

## Verification
The assertions check on every cycle that a response follows each request and that a faulting response carries a zero address. They also check that address errors leave the fault registers alone, that table faults log the request address, and that privileged high addresses come back unchanged. Only the bench scenarios show the decisions that depend on table contents: the page-size masks at their boundaries, the ASID bypass and shared entries, the separate read and write rules, the priority of multiple hits, and the first-write fault.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;

  localparam int VA_W    = 32;
  localparam int PG_BITS = 10;
  localparam int VPN_W   = VA_W - PG_BITS;

  typedef enum logic [2:0] {
    FC_ADDR_RD = 3'd0,
    FC_ADDR_WR = 3'd1,
    FC_MISS_RD = 3'd2,
    FC_MISS_WR = 3'd3,
    FC_PROT_RD = 3'd4,
    FC_PROT_WR = 3'd5,
    FC_INIT_WR = 3'd6,
    FC_MULTI   = 3'd7
  } xfault_e;

  // Strobes from the decision logic to the address datapath
  typedef struct packed {
    logic    passFull;
    logic    passLow;
    logic    useTlb;
    logic    fault;
    logic    logFault;
    xfault_e code;
  } xlat_strb_t;

  // Page mask over address bits 31:10 for each size code
  function automatic logic [VPN_W-1:0] pageMask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    case (sz)
      2'd0:    m = {VPN_W{1'b1}};
      2'd1:    m = {{(VPN_W-2){1'b1}}, 2'b0};
      2'd2:    m = {{(VPN_W-6){1'b1}}, 6'b0};
      default: m = {{(VPN_W-10){1'b1}}, 10'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dxlat_tlb_match.sv
module dxlat_tlb_match
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 19
) (
  input  logic [VPN_W-1:0]                    vaVpn,
  input  logic [ASID_W-1:0]                   curAsid,
  input  logic                                asidCheck,
  input  logic [ENTRIES-1:0]                  tlbValid,
  input  logic [ENTRIES-1:0]                  tlbShare,
  input  logic [ENTRIES-1:0]                  tlbUser,
  input  logic [ENTRIES-1:0]                  tlbWrite,
  input  logic [ENTRIES-1:0]                  tlbDirty,
  input  logic [ENTRIES-1:0][1:0]             tlbSize,
  input  logic [ENTRIES-1:0][ASID_W-1:0]      tlbAsid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]       tlbVpn,
  input  logic [ENTRIES-1:0][PPN_W-1:0]       tlbPpn,
  output logic                                anyHit,
  output logic                                multiHit,
  output logic [PPN_W-1:0]                    selPpn,
  output logic [VPN_W-1:0]                    selMask,
  output logic                                selUser,
  output logic                                selWrite,
  output logic                                selDirty
);

  logic [ENTRIES-1:0]            hitVec;
  logic [ENTRIES-1:0][VPN_W-1:0] entryMask;

  // One comparator per entry
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    logic asidOk;
    logic vpnOk;
    assign entryMask[gi] = pageMask(tlbSize[gi]);
    assign asidOk = !asidCheck || tlbShare[gi] || (tlbAsid[gi] == curAsid);
    assign vpnOk  = ((tlbVpn[gi] ^ vaVpn) & entryMask[gi]) == '0;
    assign hitVec[gi] = tlbValid[gi] && asidOk && vpnOk;
  end

  assign anyHit   = |hitVec;
  assign multiHit = |(hitVec & (hitVec - 1'b1));

  // OR-select: exact when a single entry hits
  always_comb begin
    selPpn   = '0;
    selMask  = '0;
    selUser  = 1'b0;
    selWrite = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        selPpn   = selPpn | tlbPpn[i];
        selMask  = selMask | entryMask[i];
        selUser  = selUser | tlbUser[i];
        selWrite = selWrite | tlbWrite[i];
        selDirty = selDirty | tlbDirty[i];
      end
    end
  end

endmodule

// File: rtl/dxlat_ctrl.sv
module dxlat_ctrl
  import dxlat_pkg::*;
(
  input  logic       [5:0] addrTop,
  input  logic             reqWrite,
  input  logic             privMode,
  input  logic             xlatEnable,
  input  logic             singleVirt,
  input  logic             sqLock,
  input  logic             anyHit,
  input  logic             multiHit,
  input  logic             selUser,
  input  logic             selWrite,
  input  logic             selDirty,
  output logic             asidCheck,
  output xlat_strb_t       strb
);

  logic highHalf;
  logic sqWindow;
  logic topRegion;
  logic directRegion;
  logic writeDenied;

  assign highHalf     = addrTop[5];
  assign sqWindow     = (addrTop == 6'b111000);
  assign topRegion    = (addrTop[5:3] == 3'b111);
  assign directRegion = addrTop[5] && !addrTop[4];
  assign asidCheck    = !singleVirt || !privMode;
  assign writeDenied  = privMode ? !selWrite : !(selUser && selWrite);

  always_comb begin
    strb = '0;
    if (highHalf && !privMode) begin
      if (sqWindow && !sqLock) begin
        strb.passFull = 1'b1;
      end else begin
        strb.fault = 1'b1;
        strb.code  = reqWrite ? FC_ADDR_WR : FC_ADDR_RD;
      end
    end else if (topRegion) begin
      strb.passFull = 1'b1;
    end else if (directRegion || !xlatEnable) begin
      strb.passLow = 1'b1;
    end else if (multiHit) begin
      strb.fault    = 1'b1;
      strb.logFault = 1'b1;
      strb.code     = FC_MULTI;
    end else if (!anyHit) begin
      strb.fault    = 1'b1;
      strb.logFault = 1'b1;
      strb.code     = reqWrite ? FC_MISS_WR : FC_MISS_RD;
    end else if (!reqWrite) begin
      if (!privMode && !selUser) begin
        strb.fault    = 1'b1;
        strb.logFault = 1'b1;
        strb.code     = FC_PROT_RD;
      end else begin
        strb.useTlb = 1'b1;
      end
    end else if (writeDenied) begin
      strb.fault    = 1'b1;
      strb.logFault = 1'b1;
      strb.code     = FC_PROT_WR;
    end else if (!selDirty) begin
      strb.fault    = 1'b1;
      strb.logFault = 1'b1;
      strb.code     = FC_INIT_WR;
    end else begin
      strb.useTlb = 1'b1;
    end
  end

endmodule

// File: rtl/dxlat_datapath.sv
module dxlat_datapath
  import dxlat_pkg::*;
#(
  parameter int PA_W  = 29,
  parameter int PPN_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  xlat_strb_t        strb,
  input  logic [PPN_W-1:0]  selPpn,
  input  logic [VPN_W-1:0]  selMask,
  output logic              rspValid,
  output logic [VA_W-1:0]   physAddr,
  output logic              faultFlag,
  output logic [2:0]        faultCode,
  output logic [VA_W-1:0]   faultAddr,
  output logic [VPN_W-1:0]  faultVpn
);

  localparam int PAD_W = VPN_W - PPN_W;

  logic [VPN_W-1:0] ppnWide;
  logic [VPN_W-1:0] tlbPage;
  logic [VA_W-1:0]  nextPhys;

  assign ppnWide = {{PAD_W{1'b0}}, selPpn};
  assign tlbPage = (ppnWide & selMask) | (reqAddr[VA_W-1:PG_BITS] & ~selMask);

  always_comb begin
    nextPhys = '0;
    if (strb.passFull)     nextPhys = reqAddr;
    else if (strb.passLow) nextPhys = {{(VA_W-PA_W){1'b0}}, reqAddr[PA_W-1:0]};
    else if (strb.useTlb)  nextPhys = {tlbPage, reqAddr[PG_BITS-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      physAddr  <= '0;
      faultFlag <= 1'b0;
      faultCode <= '0;
      faultAddr <= '0;
      faultVpn  <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        physAddr  <= strb.fault ? '0 : nextPhys;
        faultFlag <= strb.fault;
        faultCode <= strb.fault ? strb.code : 3'd0;
        if (strb.logFault) begin
          faultAddr <= reqAddr;
          faultVpn  <= reqAddr[VA_W-1:PG_BITS];
        end
      end
    end
  end

  // R12: every request yields a response on the following cycle
  a_r12_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R12: no address leaks out with a fault
  a_r12_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> physAddr == '0);

  // R11: plain address errors never touch the fault log
  a_r11_addr_err_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultFlag && faultCode <= 3'd1) |-> $stable(faultAddr) && $stable(faultVpn));

  // R11: table faults log the request address
  a_r11_tlb_fault_logs: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultFlag && faultCode >= 3'd2) |-> faultAddr == $past(reqAddr));

endmodule

// File: rtl/dxlat_unit.sv
module dxlat_unit
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 8,
  parameter int PA_W    = 29,
  localparam int PPN_W  = PA_W - PG_BITS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic [31:0]                        reqAddr,
  input  logic                               reqWrite,
  input  logic                               privMode,
  input  logic                               xlatEnable,
  input  logic                               singleVirt,
  input  logic                               sqLock,
  input  logic [ASID_W-1:0]                  curAsid,
  input  logic [ENTRIES-1:0]                 tlbValid,
  input  logic [ENTRIES-1:0]                 tlbShare,
  input  logic [ENTRIES-1:0]                 tlbUser,
  input  logic [ENTRIES-1:0]                 tlbWrite,
  input  logic [ENTRIES-1:0]                 tlbDirty,
  input  logic [ENTRIES-1:0][1:0]            tlbSize,
  input  logic [ENTRIES-1:0][ASID_W-1:0]     tlbAsid,
  input  logic [ENTRIES-1:0][21:0]           tlbVpn,
  input  logic [ENTRIES-1:0][PPN_W-1:0]      tlbPpn,
  output logic                               rspValid,
  output logic [31:0]                        physAddr,
  output logic                               faultFlag,
  output logic [2:0]                         faultCode,
  output logic [31:0]                        faultAddr,
  output logic [21:0]                        faultVpn
);

  logic             asidCheck;
  logic             anyHit;
  logic             multiHit;
  logic [PPN_W-1:0] selPpn;
  logic [VPN_W-1:0] selMask;
  logic             selUser;
  logic             selWrite;
  logic             selDirty;
  xlat_strb_t       strb;

  dxlat_tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .PPN_W(PPN_W)) uMatch (
    .vaVpn(reqAddr[31:PG_BITS]), .curAsid(curAsid), .asidCheck(asidCheck),
    .tlbValid(tlbValid), .tlbShare(tlbShare), .tlbUser(tlbUser),
    .tlbWrite(tlbWrite), .tlbDirty(tlbDirty), .tlbSize(tlbSize),
    .tlbAsid(tlbAsid), .tlbVpn(tlbVpn), .tlbPpn(tlbPpn),
    .anyHit(anyHit), .multiHit(multiHit), .selPpn(selPpn), .selMask(selMask),
    .selUser(selUser), .selWrite(selWrite), .selDirty(selDirty)
  );

  dxlat_ctrl uCtrl (
    .addrTop(reqAddr[31:26]), .reqWrite(reqWrite), .privMode(privMode),
    .xlatEnable(xlatEnable), .singleVirt(singleVirt), .sqLock(sqLock),
    .anyHit(anyHit), .multiHit(multiHit), .selUser(selUser),
    .selWrite(selWrite), .selDirty(selDirty),
    .asidCheck(asidCheck), .strb(strb)
  );

  dxlat_datapath #(.PA_W(PA_W), .PPN_W(PPN_W)) uPath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .strb(strb), .selPpn(selPpn), .selMask(selMask),
    .rspValid(rspValid), .physAddr(physAddr), .faultFlag(faultFlag),
    .faultCode(faultCode), .faultAddr(faultAddr), .faultVpn(faultVpn)
  );

  // R1: privileged top-region addresses come back unchanged
  a_r1_top_region_pass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privMode && reqAddr[31:29] == 3'b111) |=>
      (physAddr == $past(reqAddr) && !faultFlag));

endmodule

// File: tb/dxlat_unit_test.sv
module dxlat_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqWrite = 1'b0, privMode = 1'b0, xlatEnable = 1'b0;
  logic singleVirt = 1'b0, sqLock = 1'b0;
  logic [7:0] curAsid = '0;
  logic [N-1:0] tlbValid = '0, tlbShare = '0, tlbUser = '0, tlbWrite = '0, tlbDirty = '0;
  logic [N-1:0][1:0]  tlbSize = '0;
  logic [N-1:0][7:0]  tlbAsid = '0;
  logic [N-1:0][21:0] tlbVpn = '0;
  logic [N-1:0][18:0] tlbPpn = '0;
  logic rspValid, faultFlag;
  logic [31:0] physAddr, faultAddr;
  logic [2:0] faultCode;
  logic [21:0] faultVpn;

  int checks = 0;
  int fails = 0;
  logic [31:0] expTea = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxlat_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .privMode(privMode), .xlatEnable(xlatEnable),
    .singleVirt(singleVirt), .sqLock(sqLock), .curAsid(curAsid),
    .tlbValid(tlbValid), .tlbShare(tlbShare), .tlbUser(tlbUser),
    .tlbWrite(tlbWrite), .tlbDirty(tlbDirty), .tlbSize(tlbSize),
    .tlbAsid(tlbAsid), .tlbVpn(tlbVpn), .tlbPpn(tlbPpn),
    .rspValid(rspValid), .physAddr(physAddr), .faultFlag(faultFlag),
    .faultCode(faultCode), .faultAddr(faultAddr), .faultVpn(faultVpn)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr, priv, xe, sv, sqm;
    logic [7:0]  asid;
    logic [31:0] phys;
    logic        flt;
    logic [2:0]  code;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{32'hE0001234,1'b0,1'b1,1'b1,1'b0,1'b0,8'h05,32'hE0001234,1'b0,3'd0,8'd1},  // R1 top region
    '{32'hA1234568,1'b1,1'b1,1'b1,1'b0,1'b0,8'h05,32'h01234568,1'b0,3'd0,8'd1},  // R1 direct region
    '{32'hE3000000,1'b1,1'b1,1'b1,1'b0,1'b1,8'h05,32'hE3000000,1'b0,3'd0,8'd1},  // R1 lock ignored
    '{32'hC0001ABC,1'b0,1'b1,1'b1,1'b0,1'b0,8'h07,32'h05000ABC,1'b0,3'd0,8'd1},  // R1 C0 translated
    '{32'hC0001ABC,1'b0,1'b1,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd2,8'd4},         // R4 asid differs
    '{32'h80000000,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd0,8'd2},         // R2 user read
    '{32'hC0000000,1'b1,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd1,8'd2},         // R2 user write
    '{32'hE3FFFFFC,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'hE3FFFFFC,1'b0,3'd0,8'd2},  // R2 sq window
    '{32'hE3FFFFFC,1'b1,1'b0,1'b1,1'b0,1'b1,8'h05,32'h0,1'b1,3'd1,8'd2},         // R2 sq locked
    '{32'hE4000000,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd0,8'd2},         // R2 past window
    '{32'h7FFFFFFF,1'b0,1'b1,1'b0,1'b0,1'b0,8'h05,32'h1FFFFFFF,1'b0,3'd0,8'd3},  // R3
    '{32'h6ABCDEF0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h05,32'h0ABCDEF0,1'b0,3'd0,8'd3},  // R3 user
    '{32'hC8000000,1'b0,1'b1,1'b0,1'b0,1'b0,8'h05,32'h08000000,1'b0,3'd0,8'd3},  // R3 C0 region
    '{32'h004003FC,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h010003FC,1'b0,3'd0,8'd5},  // R5 1K top
    '{32'h00400400,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd2,8'd5},         // R5 1K edge
    '{32'h00400010,1'b0,1'b0,1'b1,1'b0,1'b0,8'h06,32'h0,1'b1,3'd2,8'd4},         // R4 mismatch
    '{32'h00400010,1'b0,1'b1,1'b1,1'b1,1'b0,8'h06,32'h01000010,1'b0,3'd0,8'd4},  // R4 bypass
    '{32'h00400010,1'b0,1'b0,1'b1,1'b1,1'b0,8'h06,32'h0,1'b1,3'd2,8'd4},         // R4 user checks
    '{32'h100ABCDE,1'b0,1'b1,1'b1,1'b0,1'b0,8'h33,32'h023ABCDE,1'b0,3'd0,8'd4},  // R4 share, 1M
    '{32'h100ABCDE,1'b0,1'b0,1'b1,1'b0,1'b0,8'h33,32'h0,1'b1,3'd4,8'd8},         // R8
    '{32'h20000FFC,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h03000FFC,1'b0,3'd0,8'd5},  // R5 4K
    '{32'h20000FFC,1'b1,1'b1,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd5,8'd9},         // R9 priv
    '{32'h100ABCDE,1'b1,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd5,8'd9},         // R9 user
    '{32'h100ABCDE,1'b1,1'b1,1'b1,1'b0,1'b0,8'h05,32'h023ABCDE,1'b0,3'd0,8'd9},  // R9 priv ok
    '{32'h004003FC,1'b1,1'b0,1'b1,1'b0,1'b0,8'h05,32'h010003FC,1'b0,3'd0,8'd9},  // R9 user ok
    '{32'h3000FFF0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd6,8'd10},        // R10
    '{32'h3000FFF0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0400FFF0,1'b0,3'd0,8'd5},  // R5 64K
    '{32'h30010000,1'b1,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd3,8'd6},         // R6 write miss
    '{32'h40000000,1'b0,1'b0,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd7,8'd7},         // R7
    '{32'h40000000,1'b1,1'b1,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd7,8'd7},         // R7 priority
    '{32'h50000000,1'b0,1'b1,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd2,8'd6},         // R6 invalid
    '{32'h3000FFF0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h05,32'h0,1'b1,3'd6,8'd10}         // R10 priv
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setEntry(input int i, input logic [31:0] va, input logic [31:0] pa,
                          input logic [1:0] sz, input logic [7:0] asid,
                          input logic sh, input logic us, input logic wr, input logic dt);
    tlbValid[i] = 1'b1; tlbShare[i] = sh; tlbUser[i] = us; tlbWrite[i] = wr;
    tlbDirty[i] = dt; tlbSize[i] = sz; tlbAsid[i] = asid;
    tlbVpn[i] = va[31:10]; tlbPpn[i] = pa[28:10];
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    setEntry(0, 32'h00400000, 32'h01000000, 2'd0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1);
    setEntry(1, 32'h10000000, 32'h02300000, 2'd3, 8'h22, 1'b1, 1'b0, 1'b1, 1'b1);
    setEntry(2, 32'h20000000, 32'h03000000, 2'd1, 8'h05, 1'b0, 1'b1, 1'b0, 1'b1);
    setEntry(3, 32'h30000000, 32'h04000000, 2'd2, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0);
    setEntry(4, 32'h40000000, 32'h00040000, 2'd0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1);
    setEntry(5, 32'h40000000, 32'h00080000, 2'd0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1);
    setEntry(6, 32'hC0001000, 32'h05000000, 2'd1, 8'h07, 1'b0, 1'b0, 1'b1, 1'b1);
    setEntry(7, 32'h50000000, 32'h06000000, 2'd0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1);
    tlbValid[7] = 1'b0;

    repeat (3) @(posedge clk);
    #1;
    // R12 / R11: reset state
    check(!rspValid && !faultFlag && physAddr == 0 && faultCode == 0, "R12 reset outputs",
          {31'b0, rspValid, physAddr}, 64'h0);
    check(faultAddr == 0 && faultVpn == 0, "R11 reset log", {faultAddr, 10'b0, faultVpn}, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqAddr = VECS[k].addr; reqWrite = VECS[k].wr;
      privMode = VECS[k].priv; xlatEnable = VECS[k].xe; singleVirt = VECS[k].sv;
      sqLock = VECS[k].sqm; curAsid = VECS[k].asid;
      if (VECS[k].flt && VECS[k].code >= 3'd2) expTea = VECS[k].addr;
      @(posedge clk);
      #1;
      check(rspValid, $sformatf("R12 valid vec %0d", k), {63'b0, rspValid}, 64'h1);
      check(physAddr == VECS[k].phys, $sformatf("R%0d phys vec %0d", VECS[k].tag, k),
            {32'b0, physAddr}, {32'b0, VECS[k].phys});
      check(faultFlag == VECS[k].flt && faultCode == VECS[k].code,
            $sformatf("R%0d fault vec %0d", VECS[k].tag, k),
            {60'b0, faultFlag, faultCode}, {60'b0, VECS[k].flt, VECS[k].code});
      check(faultAddr == expTea && faultVpn == expTea[31:10],
            $sformatf("R11 log vec %0d", k), {32'b0, faultAddr}, {32'b0, expTea});
    end

    // R12: idle cycle gives no response and keeps the log
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = 32'h00400400;
    @(posedge clk);
    #1;
    check(!rspValid, "R12 idle", {63'b0, rspValid}, 64'h0);
    check(faultAddr == expTea, "R11 idle hold", {32'b0, faultAddr}, {32'b0, expTea});

    // R11: miss logs, then an address error leaves the log in place
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h00400400; reqWrite = 1'b0; privMode = 1'b0;
    xlatEnable = 1'b1; singleVirt = 1'b0; sqLock = 1'b0; curAsid = 8'h05;
    @(posedge clk);
    #1;
    check(faultAddr == 32'h00400400 && faultVpn == 22'h1001, "R11 miss log",
          {faultAddr, 10'b0, faultVpn}, {32'h00400400, 32'h1001});
    @(negedge clk);
    reqAddr = 32'h9000_0000;
    @(posedge clk);
    #1;
    check(faultFlag && faultCode == 3'd0, "R2 user read error", {60'b0, faultFlag, faultCode}, 64'h8);
    check(faultAddr == 32'h00400400 && faultVpn == 22'h1001, "R11 addr error keeps log",
          {32'b0, faultAddr}, 64'h00400400);

    // R3: translation off ignores a matching invalid-region table
    @(negedge clk);
    reqAddr = 32'h4000_0000; xlatEnable = 1'b0;
    @(posedge clk);
    #1;
    check(!faultFlag && physAddr == 32'h0000_0000, "R3 off skips multi-hit",
          {31'b0, faultFlag, physAddr}, 64'h0);
    @(negedge clk);
    reqValid = 1'b0;

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule